// File: doc/BRIEF.md
# Block Transfer Address Sequencer

This block drives the memory side of a multi-register load or store. A single start strobe hands it a base address, a 16-bit mask of the registers to move, a direction (load or store), an addressing mode and a writeback enable. The block then issues one word request per cycle over a valid/ready handshake. Each request carries a word address and the index of the register it belongs to. The register file, the memory and the data path sit outside the block. The block only produces the address and index sequence, and at the end it produces the updated base value.

There are four core modes: increment or decrement, each with the step taken after or before the access. The block also accepts four stack-style names, which a small decoder folds onto the core modes. For these four names the result depends on whether the transfer is a load or a store. Whatever the mode, the lowest-numbered register always sits at the lowest address. When the last beat has been accepted, the block pulses done for one cycle. In that same cycle it presents the new base value, with a writeback strobe when writeback was requested.

Top module: `lsm_addr_seq`

## Requirements
- R1: After reset the block is idle: req_valid_o, busy_o, done_o and wb_valid_o are all 0.
- R2: mode_i = 0 (increment, step after access): the beats go to base, base+4, …, base+4N-4, where N is the number of set bits in reg_list_i. The register indices are issued in ascending order, and each beat's address is 4 above the previous one.
- R3: mode_i = 1 (increment, step before access): the beats go to base+4 … base+4N, in ascending index order.
- R4: mode_i = 2 (decrement, step after access): the beats go to base-4N+4 … base, in ascending index order.
- R5: mode_i = 3 (decrement, step before access): the beats go to base-4N … base-4, in ascending index order.
- R6: In the done cycle, wb_addr_o is base+4N for modes 0 and 1 and base-4N for modes 2 and 3. wb_valid_o is high only in that cycle, and only when wb_en_i was 1 at start.
- R7: The stack codes on mode_i resolve as follows. Code 4 gives mode 0 for loads and mode 3 for stores. Code 5 gives mode 2 for loads and mode 1 for stores. Code 6 gives mode 1 for loads and mode 2 for stores. Code 7 gives mode 3 for loads and mode 0 for stores.
- R8: While req_valid_o is high and req_ready_i is low, req_valid_o, req_addr_o and req_idx_o hold their values. The address advances only on an accepted beat.
- R9: done_o is high for exactly one cycle: the cycle after the last beat is accepted.
- R10: With an empty register list, no request is issued, done_o pulses in the cycle after start, and wb_addr_o equals the base.
- R11: Bits [1:0] of base_i are ignored. Every request address and the writeback value are computed from the base with those bits cleared.
- R12: A start_i pulse while busy_o is high has no effect on the transfer in progress.
- R13: req_write_o is 1 for stores (is_load_i = 0) and 0 for loads, for every beat.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, accepted only when idle |
| base_i | input | 32 | Base address |
| reg_list_i | input | 16 | Register mask, bit i selects register i |
| mode_i | input | 3 | 0..3 core modes, 4..7 stack codes |
| is_load_i | input | 1 | 1 for load, 0 for store |
| wb_en_i | input | 1 | Request base writeback |
| req_valid_o | output | 1 | Request valid |
| req_ready_i | input | 1 | Request accepted by memory |
| req_addr_o | output | 32 | Word address of the request |
| req_idx_o | output | 4 | Register index of the request |
| req_write_o | output | 1 | 1 for a store beat |
| busy_o | output | 1 | Transfer in progress or finishing |
| done_o | output | 1 | One-cycle completion pulse |
| wb_valid_o | output | 1 | Writeback strobe, only during done |
| wb_addr_o | output | 32 | Updated base value |

## Verification
The tests use one three-register list at base 0x100 in all four core modes. This separates the modes by start address and by the sign of the writeback. Sparse lists and a full 16-register list check that only set bits produce beats and that indices come out in ascending order, while the list length exercises the 4N offset arithmetic. Every stack code is driven once as a load and once as a store, so that a swapped alias entry shows up as a wrong start address. A stalled handshake with a stray start in the middle, an empty list, and a misaligned base near zero cover the holding, ignoring and alignment rules.

// File: rtl/lsm_pkg.sv
package lsm_pkg;

  localparam int AW        = 32;
  localparam int WORD_B    = 4;
  localparam int MODE_W    = 3;

  typedef enum logic [1:0] {
    AM_INC_AFTER  = 2'd0,
    AM_INC_BEFORE = 2'd1,
    AM_DEC_AFTER  = 2'd2,
    AM_DEC_BEFORE = 2'd3
  } addr_mode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIN  = 2'd2
  } seq_state_e;

  // Fold a mode code (core or stack-named) onto one of the four core modes.
  function automatic addr_mode_e resolve_mode(input logic [MODE_W-1:0] code,
                                              input logic is_load);
    addr_mode_e m;
    case (code)
      3'd0:    m = AM_INC_AFTER;
      3'd1:    m = AM_INC_BEFORE;
      3'd2:    m = AM_DEC_AFTER;
      3'd3:    m = AM_DEC_BEFORE;
      3'd4:    m = is_load ? AM_INC_AFTER  : AM_DEC_BEFORE;
      3'd5:    m = is_load ? AM_DEC_AFTER  : AM_INC_BEFORE;
      3'd6:    m = is_load ? AM_INC_BEFORE : AM_DEC_AFTER;
      default: m = is_load ? AM_DEC_BEFORE : AM_INC_AFTER;
    endcase
    return m;
  endfunction

  // Lowest address touched, given the aligned base and span = 4*N.
  function automatic logic [AW-1:0] first_addr(input addr_mode_e m,
                                               input logic [AW-1:0] b,
                                               input logic [AW-1:0] span);
    logic [AW-1:0] step;
    step = AW'(WORD_B);
    case (m)
      AM_INC_AFTER:  return b;
      AM_INC_BEFORE: return b + step;
      AM_DEC_AFTER:  return b - span + step;
      default:       return b - span;
    endcase
  endfunction

  // Base value after the transfer.
  function automatic logic [AW-1:0] final_base(input addr_mode_e m,
                                               input logic [AW-1:0] b,
                                               input logic [AW-1:0] span);
    if (m == AM_INC_AFTER || m == AM_INC_BEFORE) return b + span;
    return b - span;
  endfunction

endpackage

// File: rtl/lsm_mode_decode.sv
module lsm_mode_decode
  import lsm_pkg::*;
(
  input  logic [MODE_W-1:0] code_i,
  input  logic              is_load_i,
  output addr_mode_e        mode_o
);
  assign mode_o = resolve_mode(code_i, is_load_i);
endmodule

// File: rtl/lsm_addr_plan.sv
module lsm_addr_plan
  import lsm_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int CNT_W = $clog2(NREG + 1)
) (
  input  logic [AW-1:0]   base_i,
  input  logic [NREG-1:0] list_i,
  input  addr_mode_e      mode_i,
  output logic [AW-1:0]   first_o,
  output logic [AW-1:0]   wb_o,
  output logic            empty_o
);
  logic [CNT_W-1:0] n_regs;
  logic [AW-1:0]    span;

  always_comb begin
    n_regs = '0;
    for (int i = 0; i < NREG; i++) n_regs = n_regs + CNT_W'(list_i[i]);
  end

  assign span    = AW'(n_regs) << $clog2(WORD_B);
  assign first_o = first_addr(mode_i, base_i, span);
  assign wb_o    = final_base(mode_i, base_i, span);
  assign empty_o = (n_regs == '0);
endmodule

// File: rtl/lsm_list_scan.sv
module lsm_list_scan #(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic [NREG-1:0]  mask_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [NREG-1:0]  rest_o
);
  always_comb begin
    any_o = |mask_i;
    idx_o = '0;
    for (int i = NREG - 1; i >= 0; i--) begin
      if (mask_i[i]) idx_o = IDX_W'(i);
    end
    rest_o = mask_i & (mask_i - NREG'(1));
  end
endmodule

// File: rtl/lsm_addr_seq.sv
module lsm_addr_seq
  import lsm_pkg::*;
#(
  parameter int NREG  = 16,
  parameter int IDX_W = $clog2(NREG)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [AW-1:0]     base_i,
  input  logic [NREG-1:0]   reg_list_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              is_load_i,
  input  logic              wb_en_i,
  output logic              req_valid_o,
  input  logic              req_ready_i,
  output logic [AW-1:0]     req_addr_o,
  output logic [IDX_W-1:0]  req_idx_o,
  output logic              req_write_o,
  output logic              busy_o,
  output logic              done_o,
  output logic              wb_valid_o,
  output logic [AW-1:0]     wb_addr_o
);
  seq_state_e      state_q;
  logic [AW-1:0]   addr_q, wbval_q, base_al;
  logic [NREG-1:0] mask_q, mask_rest;
  logic            wben_q, write_q;

  addr_mode_e    core_mode;
  logic [AW-1:0] plan_first, plan_wb;
  logic          plan_empty, scan_any;

  // Named internal events
  logic start_take, req_fire, last_beat;

  assign base_al = base_i & ~AW'(WORD_B - 1);

  lsm_mode_decode u_dec (
    .code_i    (mode_i),
    .is_load_i (is_load_i),
    .mode_o    (core_mode)
  );

  lsm_addr_plan #(.NREG(NREG)) u_plan (
    .base_i  (base_al),
    .list_i  (reg_list_i),
    .mode_i  (core_mode),
    .first_o (plan_first),
    .wb_o    (plan_wb),
    .empty_o (plan_empty)
  );

  lsm_list_scan #(.NREG(NREG), .IDX_W(IDX_W)) u_scan (
    .mask_i (mask_q),
    .any_o  (scan_any),
    .idx_o  (req_idx_o),
    .rest_o (mask_rest)
  );

  assign start_take = start_i && (state_q == ST_IDLE);
  assign req_fire   = req_valid_o && req_ready_i;
  assign last_beat  = req_fire && (mask_rest == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      wbval_q <= '0;
      mask_q  <= '0;
      wben_q  <= 1'b0;
      write_q <= 1'b0;
    end else begin
      case (state_q)
        ST_IDLE: if (start_take) begin
          state_q <= plan_empty ? ST_FIN : ST_RUN;
          addr_q  <= plan_first;
          wbval_q <= plan_wb;
          mask_q  <= reg_list_i;
          wben_q  <= wb_en_i;
          write_q <= !is_load_i;
        end
        ST_RUN: if (req_fire) begin
          addr_q <= addr_q + AW'(WORD_B);
          mask_q <= mask_rest;
          if (last_beat) state_q <= ST_FIN;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_valid_o = (state_q == ST_RUN) && scan_any;
  assign req_addr_o  = addr_q;
  assign req_write_o = write_q;
  assign busy_o      = (state_q != ST_IDLE);
  assign done_o      = (state_q == ST_FIN);
  assign wb_valid_o  = done_o && wben_q;
  assign wb_addr_o   = wbval_q;

  AST_ADDR_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_fire && !last_beat) |=> (req_valid_o && req_addr_o == $past(req_addr_o) + AW'(WORD_B))); // R2
  AST_IDX_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_fire && !last_beat) |=> (req_idx_o > $past(req_idx_o))); // R2
  AST_STALL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && !req_ready_i) |=> (req_valid_o && $stable(req_addr_o) && $stable(req_idx_o))); // R8
  AST_DONE_AFTER_LAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    last_beat |=> done_o); // R9
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R9
  AST_WB_IN_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_valid_o |-> done_o); // R6
  AST_ADDR_ALIGNED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_addr_o[1:0] == 2'b00)); // R11
  AST_BUSY_IGNORES_START: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && start_i && !req_ready_i) |=> $stable(req_addr_o)); // R12
endmodule

// File: tb/lsm_addr_seq_bench.sv
module lsm_addr_seq_bench;
  localparam int CLK_PERIOD = 10;
  localparam int NV = 12;
  // {mode[2:0], load, wb, list[15:0], base[31:0]}
  localparam logic [52:0] VECS [0:NV-1] = '{
    {3'd0, 1'b1, 1'b1, 16'h000E, 32'h0000_0100},
    {3'd1, 1'b1, 1'b1, 16'h000E, 32'h0000_0100},
    {3'd2, 1'b1, 1'b1, 16'h000E, 32'h0000_0100},
    {3'd3, 1'b0, 1'b1, 16'h000E, 32'h0000_0100},
    {3'd4, 1'b0, 1'b1, 16'h4003, 32'h0000_2000},
    {3'd4, 1'b1, 1'b1, 16'h8001, 32'h0000_3000},
    {3'd5, 1'b1, 1'b1, 16'h0110, 32'h0000_3000},
    {3'd5, 1'b0, 1'b1, 16'h0110, 32'h0000_3000},
    {3'd6, 1'b1, 1'b1, 16'h0C00, 32'h0000_5000},
    {3'd6, 1'b0, 1'b1, 16'h0C00, 32'h0000_5000},
    {3'd7, 1'b1, 1'b1, 16'h0021, 32'h0000_6000},
    {3'd7, 1'b0, 1'b0, 16'hFFFF, 32'h0000_0000}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        start = 1'b0, is_load = 1'b0, wb_en = 1'b0, ready = 1'b1;
  logic [31:0] base = '0;
  logic [15:0] list = '0;
  logic [2:0]  mode = '0;
  logic        valid, wr, busy, done, wbv;
  logic [31:0] addr, wba;
  logic [3:0]  idx;
  int          n_checks = 0, n_err = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lsm_addr_seq u_lsm_addr_seq (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .base_i(base),
    .reg_list_i(list), .mode_i(mode), .is_load_i(is_load), .wb_en_i(wb_en),
    .req_valid_o(valid), .req_ready_i(ready), .req_addr_o(addr),
    .req_idx_o(idx), .req_write_o(wr), .busy_o(busy), .done_o(done),
    .wb_valid_o(wbv), .wb_addr_o(wba)
  );

  task automatic check(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      n_checks++; n_err++;
      $display("FAIL watchdog actual=0x%0h expected=0x0", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_checks);
      $finish;
    end
  end

  // Bench's own view of the addressing: ascending flag and pre-step flag.
  task automatic modes_of(input logic [2:0] c, input logic ld,
                          output bit up, output bit pre);
    case (c)
      3'd0: begin up = 1; pre = 0; end
      3'd1: begin up = 1; pre = 1; end
      3'd2: begin up = 0; pre = 0; end
      3'd3: begin up = 0; pre = 1; end
      3'd4: begin up = ld;  pre = !ld; end      // R7 full-descending
      3'd5: begin up = !ld; pre = !ld; end      // R7 full-ascending
      3'd6: begin up = ld;  pre = ld;  end      // R7 empty-descending
      default: begin up = !ld; pre = ld; end    // R7 empty-ascending
    endcase
  endtask

  task automatic run_vec(input logic [2:0] c, input logic ld, input logic we,
                         input logic [15:0] lst, input logic [31:0] b, input string tag);
    bit up, pre;
    int n, k;
    logic [31:0] ab, lo, wexp;
    modes_of(c, ld, up, pre);
    n  = $countones(lst);
    ab = {b[31:2], 2'b00};
    if (up) lo = ab + (pre ? 32'd4 : 32'd0);
    else    lo = ab - 32'(4 * n) + (pre ? 32'd0 : 32'd4);
    wexp = up ? ab + 32'(4 * n) : ab - 32'(4 * n);
    @(negedge clk);
    start = 1; mode = c; is_load = ld; wb_en = we; list = lst; base = b;
    @(negedge clk);
    start = 0;
    k = 0;
    for (int i = 0; i < 16; i++) begin
      if (lst[i]) begin
        check(valid === 1'b1, {tag, " valid"}, 32'(valid), 32'd1);
        check(addr === lo + 32'(4 * k), {tag, " addr"}, addr, lo + 32'(4 * k));
        check(idx === 4'(i), {tag, " idx"}, 32'(idx), 32'(i));
        check(wr === !ld, "R13 write flag", 32'(wr), 32'(!ld));
        k++;
        @(negedge clk);
      end
    end
    check(done === 1'b1 && valid === 1'b0, "R9 done after last beat", 32'(done), 32'd1);
    check(wbv === we, "R6 wb strobe", 32'(wbv), 32'(we));
    if (we) check(wba === wexp, "R6 wb value", wba, wexp);
    @(negedge clk);
    check(done === 1'b0 && busy === 1'b0, "R9 done single pulse", 32'(done), 32'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(valid === 0 && busy === 0 && done === 0 && wbv === 0, "R1 reset idle",
          {28'd0, valid, busy, done, wbv}, 32'd0);
    rst_n = 1;

    for (int v = 0; v < NV; v++) begin
      run_vec(VECS[v][52:50], VECS[v][49], VECS[v][48], VECS[v][47:32], VECS[v][31:0],
              (VECS[v][52:50] == 3'd0) ? "R2" : (VECS[v][52:50] == 3'd1) ? "R3" :
              (VECS[v][52:50] == 3'd2) ? "R4" : (VECS[v][52:50] == 3'd3) ? "R5" : "R7");
    end

    // R11: misaligned base near zero, decrement-before
    run_vec(3'd3, 1'b1, 1'b1, 16'h0001, 32'h0000_0007, "R11");

    // R10: empty list
    @(negedge clk);
    start = 1; mode = 3'd3; is_load = 1; wb_en = 1; list = 16'h0; base = 32'h880;
    @(negedge clk);
    start = 0;
    check(done === 1 && valid === 0, "R10 empty done", 32'(done), 32'd1);
    check(wba === 32'h880 && wbv === 1, "R10 empty wb", wba, 32'h880);
    @(negedge clk);
    check(done === 0 && valid === 0, "R10 no request", 32'(valid), 32'd0);

    // R8 / R12: stall with a stray start
    @(negedge clk);
    start = 1; mode = 3'd0; is_load = 0; wb_en = 1; list = 16'h0005; base = 32'h40;
    ready = 0;
    @(negedge clk);
    start = 0;
    for (int s = 0; s < 3; s++) begin
      check(valid === 1 && addr === 32'h40 && idx === 4'd0, "R8 stall hold", addr, 32'h40);
      if (s == 1) begin start = 1; base = 32'h900; list = 16'h8000; end
      @(negedge clk);
      start = 0;
    end
    check(addr === 32'h40 && idx === 4'd0, "R12 start ignored while busy", addr, 32'h40);
    ready = 1;
    @(negedge clk);
    check(valid === 1 && addr === 32'h44 && idx === 4'd2, "R8 advance on accept", addr, 32'h44);
    @(negedge clk);
    check(done === 1 && wba === 32'h48, "R12 original transfer completes", wba, 32'h48);
    @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_checks);
    $finish;
  end
endmodule